// File: doc/BRIEF.md
# Serial Configuration and Result Readout Port

This block sits between an external chip-select-framed serial host and an auxiliary conversion sequencer. The host shifts 16-bit instructions in on the data-in pin. Each instruction carries a 4-bit address and 12 bits of data, and it loads one of a small bank of configuration registers. Register 0 is the control register. It holds a self-clearing start bit, an averaging select, a clock-divider select and a result output-mode flag. These fields are brought out as decoded ports for the sequencer.

The serial data-out pin is released (output enable low) when idle. Writing the start bit turns the pin on and drives it high while the sequencer reports busy. When the sequencer's busy flag falls, the block captures the result and drives the pin low to signal ready. If output mode is on, the next chip-select assertion shifts the captured result out MSB first. Bits advance on serial-clock falling edges. Raising chip-select then releases the pin and clears the ready state. The three serial pins are synchronized into the system clock domain, and all edge detection takes place there.

Top module: `cfg_readout_port`

## Requirements
- R1: An instruction is shifted in MSB first on serial-clock rising edges while chip-select is low. The first 4 bits are the address and the next 12 bits are the data. When chip-select rises after exactly 16 bits, the register at that address (0 to NUM_REGS-1) is loaded with the data.
- R2: A frame of any length other than 16 bits leaves every register unchanged.
- R3: An address of NUM_REGS or above writes nothing. This includes 4'b1111, so a frame of all ones, such as DIN held high during a read, changes no register.
- R4: The control register is register 0. Its bits [6:4] appear on avg_sel_o, bits [9:7] on div_sel_o and bit 10 on out_mode_o.
- R5: Writing 1 to control bit 0 raises start_o for exactly one clock cycle. After that, the stored bit reads back as 0.
- R6: After reset, every register is zero and dout_oe_o is low.
- R7: From the cycle after start_o, dout_oe_o and dout_o are both high until the sequencer's busy_i falls.
- R8: When busy_i falls, result_i is captured and the pin is driven low, with dout_oe_o high, to show ready.
- R9: In the ready state with out_mode_o at 1, the next chip-select fall presents the result MSB first on dout_o. Each later serial-clock falling edge advances one bit, and the pin drives 0 after the LSB.
- R10: A chip-select rise that ends a readout sets dout_oe_o low. The pin stays released until the next start.
- R11: In the ready state with out_mode_o at 0, a chip-select frame shifts nothing out. dout_o stays low with dout_oe_o high, and ready persists for a later readout.
- R12: Instructions are accepted while the pin signals busy.
- R13: Serial-clock edges while chip-select is high neither shift instruction bits nor advance the readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Serial chip-select, active low |
| sclk_i | input | 1 | Serial clock, slower than clk_i/4 |
| din_i | input | 1 | Serial instruction data |
| dout_o | output | 1 | Serial status/result value |
| dout_oe_o | output | 1 | Output enable for dout_o |
| reg_q_o | output | NUM_REGS*DATA_W | All configuration registers, register 0 in the low bits |
| start_o | output | 1 | One-cycle conversion start pulse |
| avg_sel_o | output | 3 | Averaging select |
| div_sel_o | output | 3 | Clock-divider select |
| out_mode_o | output | 1 | Result output mode enable |
| busy_i | input | 1 | Sequencer busy flag |
| result_i | input | RES_W | Sequencer result, valid when busy_i falls |

## Verification
The bench builds the defaults: 4 registers of 12 bits, 4 address bits and a 10-bit result. With these sizes it can write all 128 combinations of the averaging, divider and mode fields, and send a frame to every one of the 16 addresses, so every decoded and every empty address is covered. The 10-bit result width keeps each readout short. This allows many result patterns (all ones, all zeros, alternating bits, walking ones) to be shifted out and compared bit by bit against the expected value, in both output modes. Frames of 15 and 17 bits and serial-clock toggling with chip-select high cover the rejected-frame paths.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_READY, ST_SHIFT} dout_st_e;
  localparam int START_BIT = 0;
  localparam int AVG_LSB   = 4;
  localparam int DIV_LSB   = 7;
  localparam int MODE_BIT  = 10;
  localparam int SEL_W     = 3;
endpackage

// File: rtl/cfg_port_sync.sv
module cfg_port_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d_i[i];
        s2 <= s1;
      end
    end
    assign q_o[i] = s2;
  end
endmodule

// File: rtl/cfg_port_rx.sv
module cfg_port_rx #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              sclk_rise_i,
  input  logic              din_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int INSTR_W = ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(INSTR_W + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(INSTR_W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(INSTR_W + 1);

  logic [INSTR_W-1:0] sr_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      wr_en_o <= 1'b0;
    end else begin
      wr_en_o <= cs_rise_i && (cnt_q == FULL);
      if (cs_fall_i) begin
        cnt_q <= '0;
      end else if (sclk_rise_i) begin
        sr_q  <= {sr_q[INSTR_W-2:0], din_i};
        cnt_q <= (cnt_q == OVER) ? OVER : cnt_q + 1'b1;
      end
    end
  end

  assign wr_addr_o = sr_q[INSTR_W-1 -: ADDR_W];
  assign wr_data_o = sr_q[DATA_W-1:0];
endmodule

// File: rtl/cfg_port_regs.sv
module cfg_port_regs
  import cfg_port_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 12,
  parameter int NUM_REGS = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic [NUM_REGS*DATA_W-1:0] reg_q_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (wr_en_i && wr_addr_i == ADDR_W'(i)) begin
        q <= wr_data_i;
      end else if (i == 0 && q[START_BIT]) begin
        q[START_BIT] <= 1'b0;  // start self-clears
      end
    end
    assign reg_q_o[i*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/cfg_port_dout.sv
module cfg_port_dout
  import cfg_port_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             busy_i,
  input  logic [RES_W-1:0] result_i,
  input  logic             out_mode_i,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             sclk_fall_i,
  output logic             dout_o,
  output logic             dout_oe_o,
  output dout_st_e         st_o
);
  localparam int CNT_W = $clog2(RES_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RES_W);

  dout_st_e         st_q;
  logic             busy_d;
  logic [RES_W-1:0] res_q, sh_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      busy_d <= 1'b0;
      res_q  <= '0;
      sh_q   <= '0;
      cnt_q  <= '0;
    end else begin
      busy_d <= busy_i;
      if (start_i) begin
        st_q <= ST_BUSY;
      end else begin
        unique case (st_q)
          ST_BUSY: if (busy_d && !busy_i) begin
            res_q <= result_i;
            st_q  <= ST_READY;
          end
          ST_READY: if (cs_fall_i && out_mode_i) begin
            sh_q  <= res_q;
            cnt_q <= '0;
            st_q  <= ST_SHIFT;
          end
          ST_SHIFT: begin
            if (cs_rise_i) begin
              st_q <= ST_IDLE;
            end else if (sclk_fall_i && cnt_q != LAST) begin
              sh_q  <= {sh_q[RES_W-2:0], 1'b0};
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    dout_o    = 1'b0;
    dout_oe_o = 1'b1;
    unique case (st_q)
      ST_IDLE:  dout_oe_o = 1'b0;
      ST_BUSY:  dout_o = 1'b1;
      ST_READY: dout_o = 1'b0;
      ST_SHIFT: dout_o = (cnt_q == LAST) ? 1'b0 : sh_q[RES_W-1];
      default:  dout_oe_o = 1'b0;
    endcase
  end

  assign st_o = st_q;
endmodule

// File: rtl/cfg_readout_port.sv
module cfg_readout_port
  import cfg_port_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 12,
  parameter int NUM_REGS = 4,
  parameter int RES_W    = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cs_ni,
  input  logic                       sclk_i,
  input  logic                       din_i,
  output logic                       dout_o,
  output logic                       dout_oe_o,
  output logic [NUM_REGS*DATA_W-1:0] reg_q_o,
  output logic                       start_o,
  output logic [SEL_W-1:0]           avg_sel_o,
  output logic [SEL_W-1:0]           div_sel_o,
  output logic                       out_mode_o,
  input  logic                       busy_i,
  input  logic [RES_W-1:0]           result_i
);
  logic [2:0] pins_s;
  logic cs_s, sclk_s, din_s, cs_d, sclk_d;
  logic cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] ctrl;
  dout_st_e dout_st;

  cfg_port_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
    .clk_i, .rst_ni, .d_i({din_i, sclk_i, cs_ni}), .q_o(pins_s)
  );
  assign {din_s, sclk_s, cs_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  assign cs_fall   = !cs_s && cs_d;
  assign cs_rise   = cs_s && !cs_d;
  assign sclk_rise = sclk_s && !sclk_d && !cs_s;
  assign sclk_fall = !sclk_s && sclk_d && !cs_s;

  cfg_port_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni,
    .cs_fall_i(cs_fall), .cs_rise_i(cs_rise), .sclk_rise_i(sclk_rise), .din_i(din_s),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  cfg_port_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .reg_q_o(reg_q_o)
  );

  assign ctrl       = reg_q_o[DATA_W-1:0];
  assign start_o    = ctrl[START_BIT];
  assign avg_sel_o  = ctrl[AVG_LSB +: SEL_W];
  assign div_sel_o  = ctrl[DIV_LSB +: SEL_W];
  assign out_mode_o = ctrl[MODE_BIT];

  cfg_port_dout #(.RES_W(RES_W)) u_dout (
    .clk_i, .rst_ni,
    .start_i(start_o), .busy_i, .result_i, .out_mode_i(out_mode_o),
    .cs_fall_i(cs_fall), .cs_rise_i(cs_rise), .sclk_fall_i(sclk_fall),
    .dout_o, .dout_oe_o, .st_o(dout_st)
  );
endmodule

// File: rtl/cfg_readout_port_chk.sv
module cfg_readout_port_chk
  import cfg_port_pkg::*;
(
  input logic     clk_i,
  input logic     rst_ni,
  input logic     start_o,
  input logic     dout_o,
  input logic     dout_oe_o,
  input logic     out_mode_o,
  input dout_st_e st,
  input logic     sclk_fall,
  input logic     cs_rise
);
  assert_start_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  assert_busy_drive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (dout_oe_o && dout_o));

  assert_hold_bit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_SHIFT && !sclk_fall && !cs_rise && !start_o) |=> $stable(dout_o));

  assert_no_shift_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_READY && !out_mode_o && !start_o) |=> (st != ST_SHIFT));

  assert_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_SHIFT && cs_rise && !start_o) |=> !dout_oe_o);

  assert_idle_tri_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE && !start_o) |=> (st == ST_IDLE || st == ST_BUSY));
endmodule

bind cfg_readout_port cfg_readout_port_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_o(start_o), .dout_o(dout_o),
  .dout_oe_o(dout_oe_o), .out_mode_o(out_mode_o), .st(dout_st),
  .sclk_fall(sclk_fall), .cs_rise(cs_rise)
);

// File: tb/sim_cfg_readout_port.sv
module sim_cfg_readout_port;
  localparam int NR = 4;
  localparam int DW = 12;
  localparam int RW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic dout_o, dout_oe_o, start_o, out_mode_o, busy = 1'b0;
  logic [NR*DW-1:0] reg_q_o;
  logic [2:0] avg_sel_o, div_sel_o;
  logic [RW-1:0] res_tb = '0;

  int errors = 0, checks = 0, starts = 0, busy_len = 20, bcnt = 0;
  logic [DW-1:0] mdl [NR];
  bit done = 1'b0;

  always #10 clk = ~clk;

  cfg_readout_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .din_i(din),
    .dout_o, .dout_oe_o, .reg_q_o, .start_o, .avg_sel_o, .div_sel_o, .out_mode_o,
    .busy_i(busy), .result_i(res_tb)
  );

  always @(posedge clk) if (rst_n && start_o) starts <= starts + 1;

  always @(posedge clk) begin
    if (start_o) begin
      busy <= 1'b1;
      bcnt <= busy_len;
    end else if (bcnt != 0) begin
      bcnt <= bcnt - 1;
      if (bcnt == 1) busy <= 1'b0;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NR*DW-1:0] mdl_vec();
    logic [NR*DW-1:0] v;
    for (int i = 0; i < NR; i++) v[i*DW +: DW] = mdl[i];
    return v;
  endfunction

  task automatic chk_regs(input string req);
    chk(reg_q_o === mdl_vec(), req, 64'(reg_q_o), 64'(mdl_vec()));
  endtask

  // n-bit frame; optional check of dout bit stream before each rising edge
  task automatic xfer(input logic [31:0] val, input int n, input bit rd,
                      input logic [RW-1:0] exp, input string req);
    cs_n = 1'b0;
    tick(6);
    for (int i = 0; i < n; i++) begin
      din = val[n-1-i];
      tick(6);
      if (rd && i < RW)
        chk(dout_oe_o === 1'b1 && dout_o === exp[RW-1-i], req,
            {62'd0, dout_oe_o, dout_o}, {62'd0, 1'b1, exp[RW-1-i]});
      sclk = 1'b1;
      tick(6);
      sclk = 1'b0;
    end
    tick(6);
    cs_n = 1'b1;
    din = 1'b0;
    tick(12);
  endtask

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    xfer({16'd0, a, d}, 16, 1'b0, '0, "");
    if (a < NR) mdl[a] = d;
    mdl[0][0] = 1'b0;
  endtask

  task automatic conv(input logic [RW-1:0] r, input bit mode, input bit busy_write);
    int s0;
    res_tb = r;
    s0 = starts;
    busy_len = busy_write ? 400 : 20;
    wr(4'h0, mode ? 12'h401 : 12'h001);
    chk(starts == s0 + 1, "R5", 64'(starts - s0), 64'd1);
    chk(reg_q_o[0] === 1'b0, "R5", 64'(reg_q_o[0]), 64'd0);
    chk(dout_oe_o === 1'b1 && dout_o === 1'b1, "R7", {dout_oe_o, dout_o}, 2'b11);
    if (busy_write) begin
      wr(4'h2, 12'hA5C);
      chk_regs("R12");
      chk(dout_oe_o === 1'b1 && dout_o === 1'b1, "R12", {dout_oe_o, dout_o}, 2'b11);
      tick(250);
    end else begin
      tick(30);
    end
    chk(dout_oe_o === 1'b1 && dout_o === 1'b0, "R8", {dout_oe_o, dout_o}, 2'b10);
    xfer(32'hFFFF, 16, 1'b1, mode ? r : '0, mode ? "R9" : "R11");
    chk_regs("R3");
    if (!mode) begin
      chk(dout_oe_o === 1'b1 && dout_o === 1'b0, "R11", {dout_oe_o, dout_o}, 2'b10);
      wr(4'h0, 12'h400);
      chk(starts == s0 + 1, "R11", 64'(starts - s0), 64'd1);
      xfer(32'hFFFF, 16, 1'b1, r, "R9");
    end
    chk(dout_oe_o === 1'b0, "R10", 64'(dout_oe_o), 64'd0);
    tick(20);
    chk(dout_oe_o === 1'b0, "R10", 64'(dout_oe_o), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < NR; i++) mdl[i] = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    chk(dout_oe_o === 1'b0, "R6", 64'(dout_oe_o), 64'd0);
    chk_regs("R6");

    // R4 / R1: every averaging, divider and mode combination
    for (int c = 0; c < 128; c++) begin
      logic [DW-1:0] d;
      d = {c[0], c[6], c[5:3], c[2:0], c[3:1], 1'b0};
      wr(4'h0, d);
      chk(avg_sel_o === c[2:0] && div_sel_o === c[5:3] && out_mode_o === c[6], "R4",
          {avg_sel_o, div_sel_o, out_mode_o}, {c[2:0], c[5:3], c[6]});
      chk_regs("R1");
    end
    wr(4'h0, 12'h000);

    // R1 / R3: every address
    for (int a = 1; a < 16; a++) begin
      wr(4'(a), 12'(a * 12'h111 + 12'h05A));
      chk_regs(a < NR ? "R1" : "R3");
    end

    // R2: wrong frame lengths
    xfer({16'd0, 16'h1F0E}, 15, 1'b0, '0, "");
    chk_regs("R2");
    xfer({15'd0, 17'h1_2F0E}, 17, 1'b0, '0, "");
    chk_regs("R2");

    // R13: serial clock with chip-select high
    din = 1'b1;
    for (int i = 0; i < 20; i++) begin
      sclk = 1'b1; tick(6); sclk = 1'b0; tick(6);
    end
    din = 1'b0;
    wr(4'h3, 12'h3C3);
    chk_regs("R13");

    // conversions and readouts
    conv(10'h3FF, 1'b1, 1'b1);
    conv(10'h000, 1'b1, 1'b0);
    conv(10'h2AA, 1'b0, 1'b0);
    conv(10'h155, 1'b1, 1'b0);
    for (int k = 0; k < RW; k += 3) conv(10'(1 << k), k[0], 1'b0);

    // R13: readout not advanced by serial clock while chip-select high
    conv_r13();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic conv_r13();
    res_tb = 10'h2C7;
    busy_len = 20;
    wr(4'h0, 12'h401);
    tick(40);
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b1; tick(6); sclk = 1'b0; tick(6);
    end
    xfer(32'hFFFF, 16, 1'b1, 10'h2C7, "R13");
    chk_regs("R3");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule